// File: doc/BRIEF.md
# SDRAM Activate-to-Command Timing Sequencer

This block sits on the controller side of a four-bank DDR SDRAM and turns a stream of access requests into a legal command sequence. Each request names a bank, a row, a column, a read or write direction and whether the row should be closed after the burst. The block puts one registered command per clock on the CS#/RAS#/CAS#/WE#, bank-address and address pins.

A per-bank record keeps the row each bank currently has open. A request that finds its row already open goes straight to a READ or WRITE. A request that misses first gets an ACTIVATE. Two timing minimums are enforced. The first is the activate-to-activate gap across all banks. The second is the activate-to-column gap, which is kept per bank. Both are given in picoseconds and converted to whole clocks by rounding up when the block is elaborated.

Requests use a valid/ready handshake. Ready is high only in a cycle in which the request can leave as a column command. A request stays on the inputs until it is accepted. Any cycle with nothing legal to issue carries a NOP.

Top module: `ddr_act_seq`

## Requirements
- R1: Command pins {cs_n, ras_n, cas_n, we_n} take exactly one of four values: ACTIVATE = 0011, READ = 0101, WRITE = 0100, NOP = 0111.
- R2: While reset is held and right after it, the bus shows NOP with bank and address zero, every bank counts as closed, and ready is low.
- R3: A valid request whose bank has no open row, or has a different row open, produces an ACTIVATE with the request's bank on the bank pins and its row on the address pins. The tracked open row of that bank then becomes the request's row.
- R4: Two ACTIVATE commands, to any banks, are at least ceil(TRRD_PS/TCK_PS) cycles apart. With a ratio above 2 and at most 3 this is 3 cycles.
- R5: A READ or WRITE to a bank comes at least ceil(TRCD_PS/TCK_PS) cycles after the ACTIVATE to that bank. An ACTIVATE in cycle 0 with a 3-cycle minimum allows the column command in cycle 3.
- R6: A request to the row already open in its bank issues no ACTIVATE. It goes out as a column command as soon as the bank's activate-to-column gap has passed.
- R7: On a column command the column sits in address bits [COL_W-1:0], address bit 10 carries the auto-precharge flag, and all other address bits are zero.
- R8: A column command with auto precharge marks its bank closed, so the next request to that bank, even to the same row, begins with an ACTIVATE.
- R9: Ready is high exactly when the presented request hits an open row and its bank's activate-to-column gap has passed. An accepted request appears as a column command on the next cycle.
- R10: Every cycle without an ACTIVATE, READ or WRITE is a NOP with bank pins and address pins at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_bank_i | input | BA_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_autopre_i | input | 1 | Close the row after this burst |
| req_ready_o | output | 1 | Request is taken as a column command this cycle |
| cmd_cs_n_o | output | 1 | Chip select, active low |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_ba_o | output | BA_W | Bank address |
| cmd_addr_o | output | ADDR_W | Row or column address, bit 10 = auto precharge |

## Verification
A stale or wrong open-row record shows on the bus on the very next decision. A missing ACTIVATE puts a READ or WRITE where an ACTIVATE was due, and a spurious ACTIVATE appears on a row hit. A timer that loads short or decrements wrongly moves a column command or a second ACTIVATE by one or more cycles. This is caught in that same cycle by a model that tracks the issue cycle of every ACTIVATE. A mis-set auto-precharge bit or a bank that is never closed shows up at the next request to that bank, as an ACTIVATE that is missing or extra.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [3:0] {
    CMD_ACT   = 4'b0011,
    CMD_WRITE = 4'b0100,
    CMD_READ  = 4'b0101,
    CMD_NOP   = 4'b0111
  } cmd_e;

  function automatic int unsigned ceil_cycles(int unsigned min_ps, int unsigned tck_ps);
    int unsigned c;
    c = (min_ps + tck_ps - 1) / tck_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int unsigned CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ok_o
);
  localparam int unsigned W     = (CYC < 2) ? 1 : $clog2(CYC);
  localparam int unsigned LOADV = CYC - 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= W'(LOADV);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_bank_rows.sv
module ddr_bank_rows #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 13,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             act_i,
  input  logic                             close_i,
  input  logic [BA_W-1:0]                  bank_i,
  input  logic [ROW_W-1:0]                 row_i,
  output logic [NUM_BANKS-1:0]             open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  row_o
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
        row_o[b]  <= '0;
      end else if (act_i && sel) begin
        open_o[b] <= 1'b1;
        row_o[b]  <= row_i;
      end else if (close_i && sel) begin
        open_o[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ddr_cmd_reg.sv
module ddr_cmd_reg
  import ddr_seq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned AP_BIT    = 10,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              col_i,
  input  logic              write_i,
  input  logic              autopre_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_addr_i,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  cmd_e              cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (act_i) begin
      cmd_d  = CMD_ACT;
      ba_d   = bank_i;
      addr_d = ADDR_W'(row_i);
    end else if (col_i) begin
      cmd_d          = write_i ? CMD_WRITE : CMD_READ;
      ba_d           = bank_i;
      addr_d         = ADDR_W'(col_addr_i);
      addr_d[AP_BIT] = autopre_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= CMD_NOP;
      ba_o   <= '0;
      addr_o <= '0;
    end else begin
      cmd_o  <= cmd_d;
      ba_o   <= ba_d;
      addr_o <= addr_d;
    end
  end

endmodule

// File: rtl/ddr_act_seq.sv
module ddr_act_seq
  import ddr_seq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned TCK_PS    = 8000,
  parameter int unsigned TRRD_PS   = 12000,
  parameter int unsigned TRCD_PS   = 20000,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_write_i,
  input  logic              req_autopre_i,
  output logic              req_ready_o,
  output logic              cmd_cs_n_o,
  output logic              cmd_ras_n_o,
  output logic              cmd_cas_n_o,
  output logic              cmd_we_n_o,
  output logic [BA_W-1:0]   cmd_ba_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  localparam int unsigned RRD_CYC = ceil_cycles(TRRD_PS, TCK_PS);
  localparam int unsigned RCD_CYC = ceil_cycles(TRCD_PS, TCK_PS);
  localparam int unsigned MAX_CYC = (RRD_CYC > RCD_CYC) ? RRD_CYC : RCD_CYC;
  localparam int unsigned SW      = $clog2(MAX_CYC + 1) + 1;

  logic [NUM_BANKS-1:0]            open_w;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_w;
  logic [NUM_BANKS-1:0]            rcd_ok_w;
  logic                            rrd_ok_w;
  logic                            hit_w, do_act, do_col;
  logic [3:0]                      cmd_w;

  assign hit_w       = open_w[req_bank_i] && (row_w[req_bank_i] == req_row_i);
  assign req_ready_o = hit_w && rcd_ok_w[req_bank_i];
  assign do_col      = req_valid_i && req_ready_o;
  assign do_act      = req_valid_i && !hit_w && rrd_ok_w;

  ddr_gap_timer #(.CYC(RRD_CYC)) i_rrd (
    .clk_i, .rst_ni, .load_i(do_act), .ok_o(rrd_ok_w)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rcd
    ddr_gap_timer #(.CYC(RCD_CYC)) i_rcd (
      .clk_i, .rst_ni,
      .load_i(do_act && (req_bank_i == BA_W'(b))),
      .ok_o  (rcd_ok_w[b])
    );
  end

  ddr_bank_rows #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) i_rows (
    .clk_i, .rst_ni,
    .act_i  (do_act),
    .close_i(do_col && req_autopre_i),
    .bank_i (req_bank_i),
    .row_i  (req_row_i),
    .open_o (open_w),
    .row_o  (row_w)
  );

  ddr_cmd_reg #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) i_cmd (
    .clk_i, .rst_ni,
    .act_i     (do_act),
    .col_i     (do_col),
    .write_i   (req_write_i),
    .autopre_i (req_autopre_i),
    .bank_i    (req_bank_i),
    .row_i     (req_row_i),
    .col_addr_i(req_col_i),
    .cmd_o     (cmd_w),
    .ba_o      (cmd_ba_o),
    .addr_o    (cmd_addr_o)
  );

  assign {cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o} = cmd_w;

  // bus-side gap counters for the timing checks
  logic          bus_act, bus_col;
  logic [SW-1:0] since_act_q;
  assign bus_act = (cmd_w == CMD_ACT);
  assign bus_col = (cmd_w == CMD_READ) || (cmd_w == CMD_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           since_act_q <= SW'(RRD_CYC);
    else if (bus_act)                      since_act_q <= SW'(1);
    else if (since_act_q < SW'(RRD_CYC))   since_act_q <= since_act_q + 1'b1;
  end

  AST_ACT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act |-> since_act_q >= SW'(RRD_CYC)); // R4

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    logic [SW-1:0] since_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   since_q <= SW'(RCD_CYC);
      else if (bus_act && cmd_ba_o == BA_W'(b))      since_q <= SW'(1);
      else if (since_q < SW'(RCD_CYC))               since_q <= since_q + 1'b1;
    end
    AST_COL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_col && cmd_ba_o == BA_W'(b)) |-> since_q >= SW'(RCD_CYC)); // R5
  end

  AST_LEGAL_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act || bus_col || cmd_w == CMD_NOP); // R1

  AST_ACT_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act |-> open_w[cmd_ba_o] && row_w[cmd_ba_o] == cmd_addr_o[ROW_W-1:0]); // R3

  AST_AP_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_col && cmd_addr_o[AP_BIT]) |-> !open_w[cmd_ba_o]); // R8

  AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_w == CMD_NOP) |-> cmd_ba_o == '0 && cmd_addr_o == '0); // R10

  AST_ACCEPT_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> bus_col); // R9

endmodule

// File: tb/test_ddr_act_seq.sv
module test_ddr_act_seq;
  localparam int ROW_W = 13, COL_W = 10, ADDR_W = 13;
  localparam int TCK = 8000, TRRD = 40000, TRCD = 20000;
  localparam int RRD = (TRRD + TCK - 1) / TCK;   // 5
  localparam int RCD = (TRCD + TCK - 1) / TCK;   // 3
  localparam int NREQ = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_ni;
  logic              req_valid, req_write, req_ap, req_ready;
  logic [1:0]        req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic              cs_n, ras_n, cas_n, we_n;
  logic [1:0]        ba;
  logic [ADDR_W-1:0] addr;

  ddr_act_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .TCK_PS(TCK), .TRRD_PS(TRRD), .TRCD_PS(TRCD)
  ) i_ddr_act_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .req_write_i(req_write), .req_autopre_i(req_ap),
    .req_ready_o(req_ready),
    .cmd_cs_n_o(cs_n), .cmd_ras_n_o(ras_n), .cmd_cas_n_o(cas_n), .cmd_we_n_o(we_n),
    .cmd_ba_o(ba), .cmd_addr_o(addr)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  int m_open[4], m_row[4], m_last_b[4];
  int m_last;
  logic [3:0]        e_cmd;
  logic [1:0]        e_ba;
  logic [ADDR_W-1:0] e_addr;
  string             e_tag;

  task automatic gen(int n, output int b, output int r, output int c,
                     output bit w, output bit ap, output int idle);
    case (n)
      0: begin b = 0; r = 5;  c = 3; w = 0; ap = 0; idle = 0; end  // miss -> ACT
      1: begin b = 0; r = 5;  c = 7; w = 0; ap = 1; idle = 0; end  // hit, closes
      2: begin b = 1; r = 9;  c = 1; w = 1; ap = 0; idle = 2; end
      3: begin b = 2; r = 4;  c = 2; w = 0; ap = 0; idle = 0; end  // held by act gap
      4: begin b = 0; r = 5;  c = 9; w = 0; ap = 0; idle = 0; end  // reopen after close
      5: begin b = 1; r = 10; c = 5; w = 1; ap = 1; idle = 1; end  // row conflict
      default: begin
        b = $urandom % 4; r = $urandom % 3; c = $urandom % 1024;
        w = $urandom % 2; ap = ($urandom % 4) == 0; idle = ($urandom % 3 == 0) ? 1 : 0;
      end
    endcase
  endtask

  task automatic compare_bus();
    chk({cs_n, ras_n, cas_n, we_n} == e_cmd, e_tag, {cs_n, ras_n, cas_n, we_n}, e_cmd);
    chk(ba == e_ba, {e_tag, " bank"}, ba, e_ba);
    chk(addr == e_addr, {e_tag, " R7 addr"}, addr, e_addr);
  endtask

  initial begin
    int k, nreq, idle, cb, cr, cc;
    bit need, cw, cap, hit, rcd_ok, rrd_ok, exp_ready;
    rst_ni = 1'b0; req_valid = 0; req_bank = 0; req_row = 0; req_col = 0;
    req_write = 0; req_ap = 0;
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; m_last_b[i] = -1000; end
    m_last = -1000;
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2 reset cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(ba == 0 && addr == 0, "R2 reset bus", {ba, addr}, 0);
    chk(req_ready == 1'b0, "R2 reset ready", req_ready, 0);
    rst_ni = 1'b1;
    e_cmd = 4'b0111; e_ba = 0; e_addr = 0; e_tag = "R2/R10 NOP";
    k = 0; nreq = 0; idle = 0; need = 1;
    cb = 0; cr = 0; cc = 0; cw = 0; cap = 0;
    while (nreq < NREQ || !need) begin
      @(negedge clk);
      compare_bus();
      if (need && nreq < NREQ) begin
        gen(nreq, cb, cr, cc, cw, cap, idle);
        nreq++; need = 0;
        req_bank = 2'(cb); req_row = ROW_W'(cr); req_col = COL_W'(cc);
        req_write = cw; req_ap = cap;
      end
      if (idle > 0) begin req_valid = 0; idle--; end
      else req_valid = !need;
      #1;
      hit       = m_open[cb] != 0 && m_row[cb] == cr;
      rcd_ok    = (k - m_last_b[cb]) >= RCD;
      rrd_ok    = (k - m_last) >= RRD;
      exp_ready = hit && rcd_ok;
      chk(req_ready == exp_ready, "R9 ready", req_ready, exp_ready);
      e_cmd = 4'b0111; e_ba = 0; e_addr = 0; e_tag = "R10/R1 NOP";
      if (req_valid && exp_ready) begin
        e_cmd  = cw ? 4'b0100 : 4'b0101;
        e_ba   = 2'(cb);
        e_addr = ADDR_W'(cc) | (ADDR_W'(cap) << 10);
        e_tag  = "R5/R6/R1 column";
        if (cap) m_open[cb] = 0;
        need = 1;
      end else if (req_valid && !hit && rrd_ok) begin
        e_cmd  = 4'b0011;
        e_ba   = 2'(cb);
        e_addr = ADDR_W'(cr);
        e_tag  = "R3/R4/R8 activate";
        m_open[cb] = 1; m_row[cb] = cr; m_last_b[cb] = k; m_last = k;
      end
      k++;
    end
    @(negedge clk);
    compare_bus();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule